// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Controller

This block lets a bus master read an external serial flash as if it were plain read-only memory. Software first loads a template command word that holds the read opcode, the number of address bytes, the number of dummy bytes and the lane format. From then on, every bus read to the flash window becomes one complete flash read frame: opcode, then the bus offset as the address, then dummy clocks, then data. The returned bytes are packed little-endian and the bus read is acknowledged.

The mode is left through a reset request. A frame that is already running is allowed to finish before the mode drops. A read made outside the mode, or with an unsupported size, is answered with an error and touches no flash pin. The serial engine runs in clock mode 0, with the serial clock at half the system clock. It shifts one frame at a time over one, two or four data lanes.

Top module: `flash_mem_reader`

## Requirements
- R1: After reset, stat_init=0, stat_rst=0, fl_cs_n=1, fl_sck=0, bus_ack=0 and bus_ready=1.
- R2: A template write uses this layout: opcode in [31:24], frame form in [23:21] (address bytes plus one, valid 2..5), field form in [20:19] (0 = all lanes serial, 1 = serial opcode and address with wide data), and dummy bytes in [18:16]. A valid write sets stat_init in the cycle after tmpl_we is high.
- R3: A template write with frame form outside 2..5, or with field form 2 or 3, is ignored. stat_init keeps its value, and later frames still use the previously stored template.
- R4: A bus read accepted while stat_init=0, or one with bus_size=3, is answered in the next cycle with bus_ack=1, bus_err=1 and bus_rdata=0. No frame starts (fl_cs_n stays high).
- R5: A frame drives fl_cs_n low and shifts out, on fl_io_out[0] with MSB first, the 8-bit opcode followed by the low N bytes of bus_addr (N = address bytes). It uses one bit per fl_sck period, with fl_sck at half the clock rate, changing outputs while fl_sck is low.
- R6: Dummy bytes D take 8*D fl_sck periods in serial form. In wide form they take 4*D periods (fl_lane_quad=0) or 2*D periods (fl_lane_quad=1). Data then takes 8*B, 4*B or 2*B periods for B data bytes.
- R7: Data is sampled while fl_sck is high. Serial form samples fl_io_in[1]. Wide dual form samples fl_io_in[1:0], and wide quad form samples fl_io_in[3:0]. The higher lane carries the earlier bit and each byte arrives MSB first. bus_size 0, 1 and 2 read 1, 2 and 4 bytes.
- R8: The first received byte lands in bus_rdata[7:0], the next byte in [15:8], and so on. Unused upper bytes are zero. The read is acknowledged with bus_ack=1 and bus_err=0 the cycle after the frame ends.
- R9: bus_ready is low from the cycle after a frame read is accepted until bus_ack rises. A request held during a frame starts no second frame.
- R10: A reset request sets stat_rst in the next cycle. With no frame running, stat_init and stat_rst both clear one cycle later. Bus reads accepted in the request cycle, or while stat_rst=1, get an error response and no frame.
- R11: A reset request during a frame lets that frame finish with correct data and no error. stat_init stays 1 until bus_ack and clears one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmpl_we | input | 1 | Write strobe for the template command word |
| tmpl_word | input | 32 | Template command word |
| reset_req | input | 1 | Request to leave memory mode |
| fl_lane_quad | input | 1 | Wide data on four lanes (1) or two lanes (0) |
| stat_init | output | 1 | Memory mode armed |
| stat_rst | output | 1 | Reset request pending |
| bus_req | input | 1 | Bus read request |
| bus_addr | input | ADDR_W | Byte offset in the flash window |
| bus_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: invalid |
| bus_ready | output | 1 | Request accepted at this edge when high |
| bus_ack | output | 1 | One-cycle response strobe |
| bus_err | output | 1 | Error response qualifier |
| bus_rdata | output | 32 | Read data, little-endian |
| fl_sck | output | 1 | Serial clock |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_out | output | 4 | Lane output values |
| fl_io_oe | output | 4 | Lane output enables |
| fl_io_in | input | 4 | Lane input values |

## Verification
A bus read and a reset request can arrive in the same cycle. So can a reset request and the middle of a running frame. The bench raises reset_req and bus_req together and expects an error response with no chip-select activity. It also holds a request in the cycle that follows, while stat_rst is high, and expects a second error. In a separate run it pulses reset_req partway through a long frame and judges that the data still comes back intact, without an error, before stat_init drops.

// File: rtl/flash_rd_pkg.sv
// Shared template layout, phase type and helpers for the flash read controller.
// Assumes a 32-bit template word with fixed field positions.
package flash_rd_pkg;

    localparam int OPC_LSB = 24;
    localparam int FRM_LSB = 21;
    localparam int FLD_LSB = 19;
    localparam int DMY_LSB = 16;

    typedef struct packed {
        logic [7:0] opcode;
        logic [2:0] frame_form;
        logic [1:0] field_form;
        logic [2:0] dummy;
    } tmpl_t;

    typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DMY, PH_DAT} phase_e;

    // Extract template fields from a raw command word.
    function automatic tmpl_t unpack_word(input logic [31:0] w);
        tmpl_t t;
        t.opcode     = w[OPC_LSB +: 8];
        t.frame_form = w[FRM_LSB +: 3];
        t.field_form = w[FLD_LSB +: 2];
        t.dummy      = w[DMY_LSB +: 3];
        return t;
    endfunction

    // A template is usable for 1..4 address bytes and serial or wide-data form.
    function automatic logic tmpl_valid(input tmpl_t t);
        return (t.frame_form >= 3'd2) && (t.frame_form <= 3'd5) && (t.field_form <= 2'd1);
    endfunction

endpackage

// File: rtl/mcmd_store.sv
// Holds the read template and the memory-mode flags.
// Assumes frame_active is high while the top is waiting on a frame.
module mcmd_store
    import flash_rd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_word,
    input  logic        rst_req,
    input  logic        frame_active,
    output tmpl_t       tmpl_o,
    output logic        mode_on_o,
    output logic        rst_pend_o
);
    tmpl_t tmpl_q;
    logic  mode_q, pend_q;
    tmpl_t wr_t;

    assign wr_t = unpack_word(wr_word);

    // Template capture, mode arming and deferred mode exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmpl_q <= '0;
            mode_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (rst_req) begin
                pend_q <= 1'b1;
            end else if (pend_q && !frame_active) begin
                pend_q <= 1'b0;
                mode_q <= 1'b0;
            end
            if (wr_en && !rst_req && !pend_q && tmpl_valid(wr_t)) begin
                tmpl_q <= wr_t;
                mode_q <= 1'b1;
            end
        end
    end

    assign tmpl_o     = tmpl_q;
    assign mode_on_o  = mode_q;
    assign rst_pend_o = pend_q;

    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q) |-> $past(wr_en));
    assert_leave_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q) |-> ($past(pend_q) && !$past(frame_active)));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && frame_active && mode_q) |=> mode_q);
endmodule

// File: rtl/frame_shifter.sv
// Runs one serial flash read frame: opcode, address, dummy clocks, data.
// Clock mode 0, serial clock at half the system clock; start only when idle.
module frame_shifter
    import flash_rd_pkg::*;
#(
    parameter int CNT_W = 7
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [31:0] addr,
    input  logic [2:0]  addr_bytes,
    input  logic [2:0]  dummy_bytes,
    input  logic [2:0]  data_bytes,
    input  logic [1:0]  lane,
    output logic        sck,
    output logic        cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in,
    output logic        busy,
    output logic        done,
    output logic [31:0] rx_data
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      sout, addr_q, rx;
    logic [1:0]       lane_q;
    logic [2:0]       abytes_q, dummy_q, data_q;
    logic             sck_q, cs_q, busy_q, done_q;
    logic [5:0]       align;

    // Clock periods needed to move a byte count over the given lane width.
    function automatic logic [CNT_W-1:0] clocks_for(input logic [2:0] nbytes, input logic [1:0] l);
        logic [CNT_W-1:0] bits;
        bits = CNT_W'({nbytes, 3'b000});
        return bits >> l;
    endfunction

    // Shift one sample of the active lanes into the receive register.
    function automatic logic [31:0] shift_rx(input logic [31:0] r, input logic [3:0] d, input logic [1:0] l);
        case (l)
            2'd0:    return {r[30:0], d[1]};
            2'd1:    return {r[29:0], d[1:0]};
            default: return {r[27:0], d[3:0]};
        endcase
    endfunction

    assign align = {(3'd4 - addr_bytes), 3'b000};

    // Frame sequencer: toggles the serial clock and walks the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OPC;  cnt <= '0;  sout <= '0;  addr_q <= '0;  rx <= '0;
            lane_q <= '0;  abytes_q <= '0;  dummy_q <= '0;  data_q <= '0;
            sck_q <= 1'b0;  cs_q <= 1'b1;  busy_q <= 1'b0;  done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q   <= 1'b1;
                cs_q     <= 1'b0;
                sck_q    <= 1'b0;
                phase    <= PH_OPC;
                cnt      <= CNT_W'(8);
                sout     <= {opcode, 24'h0};
                addr_q   <= addr << align;
                rx       <= '0;
                lane_q   <= lane;
                abytes_q <= addr_bytes;
                dummy_q  <= dummy_bytes;
                data_q   <= data_bytes;
            end else if (busy_q) begin
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else begin
                    sck_q <= 1'b0;
                    if (phase == PH_DAT) rx <= shift_rx(rx, io_in, lane_q);
                    if (cnt == CNT_W'(1)) begin
                        case (phase)
                            PH_OPC: begin
                                phase <= PH_ADR;
                                cnt   <= clocks_for(abytes_q, 2'd0);
                                sout  <= addr_q;
                            end
                            PH_ADR: begin
                                if (dummy_q != 3'd0) begin
                                    phase <= PH_DMY;
                                    cnt   <= clocks_for(dummy_q, lane_q);
                                end else begin
                                    phase <= PH_DAT;
                                    cnt   <= clocks_for(data_q, lane_q);
                                end
                            end
                            PH_DMY: begin
                                phase <= PH_DAT;
                                cnt   <= clocks_for(data_q, lane_q);
                            end
                            default: begin
                                busy_q <= 1'b0;
                                cs_q   <= 1'b1;
                                done_q <= 1'b1;
                            end
                        endcase
                    end else begin
                        cnt  <= cnt - CNT_W'(1);
                        sout <= {sout[30:0], 1'b0};
                    end
                end
            end
        end
    end

    logic hdr_phase;
    assign hdr_phase = busy_q && (phase == PH_OPC || phase == PH_ADR);
    assign io_out    = {3'b000, hdr_phase ? sout[31] : 1'b0};
    assign io_oe     = !busy_q ? 4'b0000 : (hdr_phase || lane_q == 2'd0) ? 4'b0001 : 4'b0000;
    assign sck       = sck_q;
    assign cs_n      = cs_q;
    assign busy      = busy_q;
    assign done      = done_q;
    assign rx_data   = rx;

    assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |-> !sck_q);
    assert_cs_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_q) |-> $past(start));
    assert_done_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> cs_q);
endmodule

// File: rtl/flash_mem_reader.sv
// Top: turns bus reads into flash read frames once a template is armed.
// Assumes one outstanding read; requests are accepted only when bus_ready is high.
module flash_mem_reader
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 24
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmpl_we,
    input  logic [31:0]       tmpl_word,
    input  logic              reset_req,
    input  logic              fl_lane_quad,
    output logic              stat_init,
    output logic              stat_rst,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output logic              bus_ready,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [31:0]       bus_rdata,
    output logic              fl_sck,
    output logic              fl_cs_n,
    output logic [3:0]        fl_io_out,
    output logic [3:0]        fl_io_oe,
    input  logic [3:0]        fl_io_in
);
    tmpl_t       tmpl;
    logic        mode_on, rst_pend;
    logic        running, ack_q, err_q;
    logic [31:0] rdata_q, rx;
    logic [2:0]  nb_q, nbytes;
    logic [1:0]  lane;
    logic        accept, serve, start, sh_busy, sh_done;

    // Reorder received bytes so the earliest byte sits lowest.
    function automatic logic [31:0] to_le(input logic [31:0] r, input logic [2:0] nb);
        logic [31:0] o;
        o = '0;
        for (int k = 0; k < 4; k++)
            if (k < int'(nb)) o[8*k +: 8] = r[8*(int'(nb) - 1 - k) +: 8];
        return o;
    endfunction

    mcmd_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(tmpl_we), .wr_word(tmpl_word),
        .rst_req(reset_req), .frame_active(running),
        .tmpl_o(tmpl), .mode_on_o(mode_on), .rst_pend_o(rst_pend)
    );

    assign accept = bus_req && !running;
    assign serve  = mode_on && !rst_pend && !reset_req && (bus_size != 2'd3);
    assign start  = accept && serve;
    assign nbytes = 3'd1 << bus_size;
    assign lane   = (tmpl.field_form == 2'd1) ? (fl_lane_quad ? 2'd2 : 2'd1) : 2'd0;

    frame_shifter #(.CNT_W(7)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start),
        .opcode(tmpl.opcode), .addr(32'(bus_addr)),
        .addr_bytes(tmpl.frame_form - 3'd1), .dummy_bytes(tmpl.dummy),
        .data_bytes(nbytes), .lane(lane),
        .sck(fl_sck), .cs_n(fl_cs_n), .io_out(fl_io_out), .io_oe(fl_io_oe),
        .io_in(fl_io_in), .busy(sh_busy), .done(sh_done), .rx_data(rx)
    );

    // Bus response sequencing: error replies, frame tracking, data return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
            nb_q    <= '0;
        end else begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
            if (accept && !serve) begin
                ack_q   <= 1'b1;
                err_q   <= 1'b1;
                rdata_q <= '0;
            end
            if (start) begin
                running <= 1'b1;
                nb_q    <= nbytes;
            end
            if (running && sh_done) begin
                running <= 1'b0;
                ack_q   <= 1'b1;
                rdata_q <= to_le(rx, nb_q);
            end
        end
    end

    assign bus_ready = !running;
    assign bus_ack   = ack_q;
    assign bus_err   = err_q;
    assign bus_rdata = rdata_q;
    assign stat_init = mode_on;
    assign stat_rst  = rst_pend;

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !bus_ready);
    assert_err_noframe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_err) |-> fl_cs_n);
    assert_start_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> mode_on);
    assert_ack_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !bus_err) |-> $past(running));
endmodule

// File: tb/sim_flash_mem_reader.sv
module sim_flash_mem_reader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmpl_we = 1'b0;
    logic [31:0] tmpl_word = '0;
    logic        reset_req = 1'b0;
    logic        stat_init, stat_rst;
    logic        bus_req = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_ready, bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic        fl_sck, fl_cs_n;
    logic [3:0]  fl_io_out, fl_io_oe, fl_io_in;

    int n_checks = 0;
    int n_fail   = 0;

    // Flash model configuration as the bench believes it is armed.
    logic [7:0]  cur_op = '0;
    int          cur_a = 1, cur_dm = 0, cur_form = 0;
    logic        cur_quad = 1'b0;
    logic [31:0] exp_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_mem_reader #(.ADDR_W(24)) u0 (
        .clk(clk), .rst_n(rst_n), .tmpl_we(tmpl_we), .tmpl_word(tmpl_word),
        .reset_req(reset_req), .fl_lane_quad(cur_quad),
        .stat_init(stat_init), .stat_rst(stat_rst),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_ready(bus_ready), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .fl_sck(fl_sck), .fl_cs_n(fl_cs_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
        .fl_io_in(fl_io_in)
    );

    function automatic logic [7:0] fbyte(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic int lanew();
        return (cur_form == 1) ? (cur_quad ? 4 : 2) : 1;
    endfunction

    // Lane values the flash presents for the current serial clock count.
    function automatic logic [3:0] model_io(input int rc);
        int w, j, b, sh;
        logic [7:0] by, bits;
        w = lanew();
        j = rc - 1 - (8 + 8*cur_a) - (cur_dm*8)/w;
        if (j < 0) return 4'h0;
        b  = j * w;
        by = fbyte(exp_addr + 32'(b/8));
        sh = 8 - (b % 8) - w;
        bits = by >> sh;
        if (w == 1) return {2'b00, bits[0], 1'b0};
        if (w == 2) return {2'b00, bits[1:0]};
        return bits[3:0];
    endfunction

    int          rise_cnt = 0;
    int          frames = 0;
    logic [63:0] hdr = '0;

    always @(posedge fl_sck or negedge fl_cs_n) begin
        if (!fl_sck) begin
            rise_cnt <= 0;
            hdr      <= '0;
            frames   <= frames + 1;
        end else begin
            if (rise_cnt < 8 + 8*cur_a) hdr <= {hdr[62:0], fl_io_out[0]};
            rise_cnt <= rise_cnt + 1;
        end
    end

    always_comb fl_io_in = fl_cs_n ? 4'h0 : model_io(rise_cnt);

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_raw(input logic [31:0] w);
        @(negedge clk); tmpl_word = w; tmpl_we = 1'b1;
        @(negedge clk); tmpl_we = 1'b0;
    endtask

    task automatic arm(input logic [7:0] op, input int a, input int dm, input int form, input logic quad);
        cur_op = op; cur_a = a; cur_dm = dm; cur_form = form; cur_quad = quad;
        write_raw({op, 3'(a + 1), 2'(form), 3'(dm), 16'h0});
        check(stat_init == 1'b1, "R2 stat_init after template write", 64'(stat_init), 64'd1);
    endtask

    task automatic do_read(input logic [23:0] a, input logic [1:0] sz, input logic hold,
                           output logic err, output logic [31:0] data, output int stall_bad);
        int waited;
        @(negedge clk); bus_addr = a; bus_size = sz; bus_req = 1'b1;
        while (!bus_ready) @(negedge clk);
        @(negedge clk);
        if (!hold) bus_req = 1'b0;
        stall_bad = 0; waited = 0;
        while (!bus_ack && waited < 2000) begin
            if (bus_ready) stall_bad++;
            @(negedge clk); waited++;
        end
        bus_req = 1'b0;
        check(waited < 2000, "R8 response arrives", 64'(waited), 64'd0);
        err = bus_err; data = bus_rdata;
    endtask

    // Frame read with full checks against the bench flash model.
    task automatic frame_read(input logic [23:0] a, input logic [1:0] sz, input logic hold);
        logic err; logic [31:0] data, exp_d; int sb, n, w, f0;
        logic [63:0] mask, exp_hdr;
        n = 1 << sz; w = lanew();
        mask = (64'd1 << (8*cur_a)) - 64'd1;
        exp_addr = 32'(64'(a) & mask);
        exp_d = '0;
        for (int k = 0; k < n; k++) exp_d[8*k +: 8] = fbyte(exp_addr + 32'(k));
        exp_hdr = (64'(cur_op) << (8*cur_a)) | 64'(exp_addr);
        f0 = frames;
        do_read(a, sz, hold, err, data, sb);
        check(err == 1'b0, "R8 no error on frame read", 64'(err), 64'd0);
        check(data == exp_d, "R7 R8 read data little-endian", 64'(data), 64'(exp_d));
        check(hdr == exp_hdr, "R5 opcode and address bits", hdr, exp_hdr);
        check(rise_cnt == 8 + 8*cur_a + (cur_dm*8)/w + (n*8)/w, "R6 clock count",
              64'(rise_cnt), 64'(8 + 8*cur_a + (cur_dm*8)/w + (n*8)/w));
        check(frames == f0 + 1, "R9 exactly one frame", 64'(frames), 64'(f0 + 1));
        check(sb == 0, "R9 bus_ready low during frame", 64'(sb), 64'd0);
    endtask

    task automatic err_read(input logic [23:0] a, input logic [1:0] sz, input string tag);
        logic err; logic [31:0] data; int sb, f0;
        f0 = frames;
        do_read(a, sz, 1'b0, err, data, sb);
        check(err == 1'b1, {tag, " error flag"}, 64'(err), 64'd1);
        check(data == 32'h0, {tag, " error data"}, 64'(data), 64'd0);
        check(frames == f0, {tag, " no frame"}, 64'(frames), 64'(f0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic err; logic [31:0] data; int sb, f0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(stat_init == 0 && stat_rst == 0, "R1 status after reset", {stat_init, stat_rst}, 0);
        check(fl_cs_n == 1 && fl_sck == 0, "R1 flash pins idle", {fl_cs_n, fl_sck}, 64'h2);
        check(bus_ack == 0 && bus_ready == 1, "R1 bus idle", {bus_ack, bus_ready}, 64'h1);

        // R4: read before arming
        err_read(24'h000100, 2'd2, "R4 read outside mode");

        // R3: invalid templates leave the mode off
        write_raw({8'h0B, 3'd1, 2'd0, 3'd0, 16'h0});
        check(stat_init == 0, "R3 frame form 1 rejected", 64'(stat_init), 0);
        write_raw({8'h0B, 3'd6, 2'd0, 3'd0, 16'h0});
        check(stat_init == 0, "R3 frame form 6 rejected", 64'(stat_init), 0);
        write_raw({8'h0B, 3'd4, 2'd2, 3'd0, 16'h0});
        check(stat_init == 0, "R3 field form 2 rejected", 64'(stat_init), 0);

        // R2 arming, directed reads of every size
        arm(8'h0B, 3, 1, 0, 1'b0);
        frame_read(24'h123456, 2'd0, 1'b0);
        frame_read(24'h0000FF, 2'd1, 1'b0);
        frame_read(24'hABCDEF, 2'd2, 1'b0);
        err_read(24'h000010, 2'd3, "R4 size 3");

        // R3: invalid write after arming keeps old template
        write_raw({8'hEE, 3'd7, 2'd0, 3'd0, 16'h0});
        check(stat_init == 1, "R3 mode kept after bad write", 64'(stat_init), 1);
        frame_read(24'h00A0B0, 2'd2, 1'b0);

        // R6 R7: wide dual and quad forms, no dummy and max dummy
        arm(8'h3B, 3, 1, 1, 1'b0);
        frame_read(24'h010203, 2'd2, 1'b0);
        arm(8'h6B, 4, 0, 1, 1'b1);
        frame_read(24'hFFFFFE, 2'd2, 1'b0);
        arm(8'hEB, 1, 7, 1, 1'b1);
        frame_read(24'h000042, 2'd1, 1'b0);

        // R9: held request gives one frame only
        arm(8'h03, 2, 0, 0, 1'b0);
        frame_read(24'h004321, 2'd2, 1'b1);

        // Random mix
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 0)
                arm(8'($urandom), int'($urandom_range(1, 4)), int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 1)), 1'($urandom));
            if (i % 13 == 7) err_read(24'($urandom), 2'd3, "R4 random size 3");
            else frame_read(24'($urandom), 2'($urandom_range(0, 2)), 1'b0);
        end

        // R10: reset request and bus read in the same cycle, then while pending
        arm(8'h0B, 3, 1, 0, 1'b0);
        f0 = frames;
        @(negedge clk); reset_req = 1'b1; bus_req = 1'b1; bus_addr = 24'h10; bus_size = 2'd0;
        @(negedge clk); reset_req = 1'b0;
        check(bus_ack && bus_err, "R10 read in request cycle errors", {bus_ack, bus_err}, 64'h3);
        check(stat_rst == 1 && stat_init == 1, "R10 pending visible", {stat_init, stat_rst}, 64'h3);
        @(negedge clk); bus_req = 1'b0;
        check(bus_ack && bus_err, "R10 read while pending errors", {bus_ack, bus_err}, 64'h3);
        check(stat_rst == 0 && stat_init == 0, "R10 mode left", {stat_init, stat_rst}, 0);
        check(frames == f0, "R10 no frame started", 64'(frames), 64'(f0));
        err_read(24'h20, 2'd0, "R10 read after exit");

        // R11: reset request during a frame
        arm(8'h0B, 3, 2, 0, 1'b0);
        fork
            begin
                logic [31:0] exp_d;
                exp_addr = 32'h00BEEF;
                exp_d = '0;
                for (int k = 0; k < 4; k++) exp_d[8*k +: 8] = fbyte(exp_addr + 32'(k));
                do_read(24'h00BEEF, 2'd2, 1'b0, err, data, sb);
                check(err == 0, "R11 frame completes without error", 64'(err), 0);
                check(data == exp_d, "R11 frame data intact", 64'(data), 64'(exp_d));
                check(stat_init == 1, "R11 mode held until ack", 64'(stat_init), 1);
            end
            begin
                repeat (20) @(negedge clk);
                reset_req = 1'b1;
                @(negedge clk); reset_req = 1'b0;
                check(stat_rst == 1 && stat_init == 1, "R11 pending during frame",
                      {stat_init, stat_rst}, 64'h3);
            end
        join
        @(negedge clk);
        check(stat_init == 0 && stat_rst == 0, "R11 mode left after ack", {stat_init, stat_rst}, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule